// File: doc/BRIEF.md
# Banked Level Interrupt Controller

This block gathers level-sensitive interrupt lines into banks of 32 and turns them into three request outputs: a normal request, a fast request and an endpoint request. Each bank exposes a live cause word, which mirrors the current levels of its 32 lines, and three enable words, one for each request output. A request output is high when any line, in any bank, is high and has its bit set in the enable word for that output. Software programs the enable words over a simple word-wide read/write port and reads the cause word to see which lines are active.

The number of banks is a build-time parameter. Bank `n` serves global lines `32n` to `32n+31`, and its four words sit at byte address `0x10*n`. Lines are not latched, so a line that drops removes its request without software action. All three request outputs are registered.

Top module: `banked_intc`

## Requirements
- R1: Bank n serves `src_lvl[32n+31:32n]`. Bit k of the cause word at byte address `0x10*n + 0x0` equals the current level of `src_lvl[32n+k]`, and that level appears on `bus_rdata` in the same cycle without being latched.
- R2: In each bank, the normal enable word is at offset `0x4`, the fast enable word at `0x8` and the endpoint enable word at `0xC`. A write (`bus_we` high at a clock edge) stores `bus_wdata` in the addressed word, and a later read returns the stored value. The bank index is `bus_addr[AW-1:4]`, the word select is `bus_addr[3:2]`, and `bus_addr[1:0]` is ignored.
- R3: The cause word is read-only. A write to offset `0x0` changes no enable word and does not change what the cause word reads back.
- R4: Reset (`rst_n` low, asynchronous) clears every enable word to zero, and all three request outputs are low during reset and after it.
- R5: `req_norm` at a clock edge takes the OR over all banks of (live levels AND normal enable word), using the values present just before that edge. It therefore follows a source or enable change one clock later.
- R6: `req_fast` behaves as in R5, using the fast enable words.
- R7: `req_ep` behaves as in R5, using the endpoint enable words.
- R8: A read whose bank index is NBANK or higher returns zero. A write to such an address changes no enable word.
- R9: An enable bit set to 1 enables its line. After zero is written to an enable word, no line of that bank can raise the matching output, even when all of its lines are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_lvl | input | 32*NBANK | Interrupt line levels; bank n uses bits 32n+31:32n |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr | input | AW | Byte address of the word to read or write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| req_norm | output | 1 | Normal interrupt request, registered |
| req_fast | output | 1 | Fast interrupt request, registered |
| req_ep | output | 1 | Endpoint request, registered |

## Verification
Read data is combinational, so the bench checks `bus_rdata` in the same cycle the address is driven. That check happens after the inputs settle, which is before the edge that commits any write. An enable write takes effect at the edge it is presented on, and each request output is registered at that same edge. So an output reflects a given source vector one edge after that vector is driven, and reflects a new enable word at the second edge after the write. The bench models exactly this order. It works out the expected outputs from the levels and enable words in force before each edge, then applies the write to its model, and compares the outputs half a cycle after the edge.

// File: rtl/banked_intc.sv
module banked_intc #(
  parameter int NBANK = 2,
  parameter int AW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [32*NBANK-1:0] src_lvl,
  input  logic                bus_we,
  input  logic [AW-1:0]       bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                req_norm,
  output logic                req_fast,
  output logic                req_ep
);
  localparam int NSRC = 32 * NBANK;
  localparam int BW   = AW - 4;

  logic [NSRC-1:0] m_norm, m_fast, m_ep;

  wire [BW-1:0] bsel = bus_addr[AW-1:4];
  wire [1:0]    rsel = bus_addr[3:2];
  wire          hit  = int'(bsel) < NBANK;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    wire wsel = bus_we && hit && (int'(bsel) == b);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m_norm[32*b +: 32] <= '0;
        m_fast[32*b +: 32] <= '0;
        m_ep[32*b +: 32]   <= '0;
      end else if (wsel) begin
        case (rsel)
          2'd1: m_norm[32*b +: 32] <= bus_wdata;
          2'd2: m_fast[32*b +: 32] <= bus_wdata;
          2'd3: m_ep[32*b +: 32]   <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (hit && int'(bsel) == b) begin
        case (rsel)
          2'd0: bus_rdata = src_lvl[32*b +: 32];
          2'd1: bus_rdata = m_norm[32*b +: 32];
          2'd2: bus_rdata = m_fast[32*b +: 32];
          default: bus_rdata = m_ep[32*b +: 32];
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_norm <= 1'b0;
      req_fast <= 1'b0;
      req_ep   <= 1'b0;
    end else begin
      req_norm <= |(src_lvl & m_norm);
      req_fast <= |(src_lvl & m_fast);
      req_ep   <= |(src_lvl & m_ep);
    end
  end
endmodule

// File: rtl/banked_intc_chk.sv
module banked_intc_chk #(
  parameter int NBANK = 2,
  parameter int AW    = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [32*NBANK-1:0] src_lvl,
  input logic                bus_we,
  input logic [AW-1:0]       bus_addr,
  input logic [31:0]         bus_wdata,
  input logic [31:0]         bus_rdata,
  input logic                req_norm,
  input logic                req_fast,
  input logic                req_ep,
  input logic [32*NBANK-1:0] m_norm,
  input logic [32*NBANK-1:0] m_fast,
  input logic [32*NBANK-1:0] m_ep
);
  wire        hit = int'(bus_addr[AW-1:4]) < NBANK;
  wire [1:0]  rs  = bus_addr[3:2];
  wire [31:0] sh  = 32'(bus_addr[AW-1:4]) * 32;

  p_reset_r4: assert property (@(posedge clk) !rst_n |-> (!req_norm && !req_fast && !req_ep));

  p_norm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_norm == $past(|(src_lvl & m_norm)));
  p_fast_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_fast == $past(|(src_lvl & m_fast)));
  p_ep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ep == $past(|(src_lvl & m_ep)));

  p_cause_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && rs == 2'd0) |=> ($stable(m_norm) && $stable(m_fast) && $stable(m_ep)));

  p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (bus_rdata == 32'd0));

  p_unmapped_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !hit) |=> ($stable(m_norm) && $stable(m_fast) && $stable(m_ep)));

  p_cause_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && rs == 2'd0) |-> (bus_rdata == 32'(src_lvl >> sh)));

  p_norm_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && hit && rs == 2'd1) |=> (32'(m_norm >> $past(sh)) == $past(bus_wdata)));
endmodule

bind banked_intc banked_intc_chk #(.NBANK(NBANK), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .req_norm(req_norm), .req_fast(req_fast), .req_ep(req_ep),
  .m_norm(m_norm), .m_fast(m_fast), .m_ep(m_ep)
);

// File: tb/banked_intc_tb_top.sv
`timescale 1ns/1ps
module banked_intc_tb_top;
  localparam int NB = 2;
  localparam int AW = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b1;
  logic [32*NB-1:0] src_lvl = '0;
  logic           bus_we = 1'b0;
  logic [AW-1:0]  bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic           req_norm, req_fast, req_ep;

  int compared = 0;
  int mismatched = 0;

  logic [31:0] em [NB][3];
  logic exp_n = 1'b0, exp_f = 1'b0, exp_e = 1'b0;

  always #2.5 clk = ~clk;

  banked_intc #(.NBANK(NB), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req_norm(req_norm), .req_fast(req_fast), .req_ep(req_ep)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [AW-1:0] a, input logic [32*NB-1:0] s);
    int b = int'(a[AW-1:4]);
    if (b >= NB) return 32'd0;
    if (a[3:2] == 2'd0) return s[32*b +: 32];
    return em[b][int'(a[3:2]) - 1];
  endfunction

  function automatic string read_tag(input logic [AW-1:0] a);
    if (int'(a[AW-1:4]) >= NB) return "R8 unmapped read";
    if (a[3:2] == 2'd0) return "R1/R3 cause read";
    return "R2 enable read";
  endfunction

  function automatic logic any_req(input int k, input logic [32*NB-1:0] s);
    logic r = 1'b0;
    for (int b = 0; b < NB; b++) r |= |(s[32*b +: 32] & em[b][k]);
    return r;
  endfunction

  task automatic step(input bit we, input logic [AW-1:0] a, input logic [31:0] d,
                      input logic [32*NB-1:0] s);
    @(negedge clk);
    check("R5 req_norm", 32'(req_norm), 32'(exp_n));
    check("R6 req_fast", 32'(req_fast), 32'(exp_f));
    check("R7 req_ep",   32'(req_ep),   32'(exp_e));
    bus_we = we; bus_addr = a; bus_wdata = d; src_lvl = s;
    #1;
    check(read_tag(a), bus_rdata, exp_read(a, s));
    exp_n = any_req(0, s);
    exp_f = any_req(1, s);
    exp_e = any_req(2, s);
    if (we && int'(a[AW-1:4]) < NB && a[3:2] != 2'd0)
      em[int'(a[AW-1:4])][int'(a[3:2]) - 1] = d;
  endtask

  function automatic logic [31:0] sparse();
    return $urandom & $urandom & $urandom;
  endfunction

  initial begin
    #400000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int b = 0; b < NB; b++) for (int k = 0; k < 3; k++) em[b][k] = '0;
    #1 rst_n = 1'b0;
    src_lvl = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R4 req_norm in reset", 32'(req_norm), 0);
    check("R4 req_fast in reset", 32'(req_fast), 0);
    check("R4 req_ep in reset",   32'(req_ep),   0);
    rst_n = 1'b1;
    src_lvl = '0;
    // R4: enable words read zero after reset
    for (int b = 0; b < NB; b++)
      for (int k = 1; k < 4; k++) step(0, AW'(16*b + 4*k), 0, '1);
    step(0, 8'h00, 0, '0);

    // R1: line 40 maps to bank 1 bit 8
    step(0, 8'h10, 0, 64'(1) << 40);
    step(1, 8'h14, 32'h0000_0100, 64'(1) << 40);
    step(0, 8'h14, 0, 64'(1) << 40);
    step(0, 8'h10, 0, 64'(1) << 40);
    step(0, 8'h10, 0, '0);

    // R3: write to cause word is ignored
    step(1, 8'h00, 32'hFFFF_FFFF, '0);
    step(0, 8'h00, 0, '0);
    step(0, 8'h04, 0, '0);

    // R6, R7: fast and endpoint paths individually
    step(1, 8'h08, 32'h8000_0000, '0);
    step(1, 8'h1C, 32'h0000_0001, '0);
    step(0, 8'h08, 0, 64'h0000_0000_8000_0000);
    step(0, 8'h1C, 0, 64'h0000_0001_0000_0000);
    step(0, 8'h00, 0, '0);

    // R9: writing zero to enable words disables every line
    step(1, 8'h04, 32'hFFFF_FFFF, '1);
    step(0, 8'h04, 0, '1);
    step(1, 8'h04, 32'h0, '1);
    step(1, 8'h14, 32'h0, '1);
    step(1, 8'h08, 32'h0, '1);
    step(1, 8'h1C, 32'h0, '1);
    step(0, 8'h04, 0, '1);
    step(0, 8'h14, 0, '1);

    // R8: unmapped write is ignored, read is zero
    step(1, 8'h24, 32'hFFFF_FFFF, '1);
    step(0, 8'h24, 0, '1);
    step(0, 8'hF8, 0, '1);
    step(0, 8'h04, 0, '1);

    // random traffic across all rules
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] a;
      logic [32*NB-1:0] s;
      a = ($urandom % 4 == 0) ? AW'($urandom) : AW'($urandom % (16*NB));
      s = ($urandom % 5 == 0) ? '0 : {sparse(), sparse()};
      step(($urandom % 3) == 0, a, ($urandom % 4 == 0) ? 32'h0 : sparse(), s);
    end
    step(0, 8'h00, 0, '0);
    step(0, 8'h00, 0, '0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule